// File: doc/BRIEF.md
# Complex Apodization Window Multiplier

This block shapes each acquired spectral line before a downstream FFT. Every real input sample is multiplied by a complex coefficient taken from a window table. The coefficient sets the amplitude (apodization) and the phase (dispersion correction) applied to that point. Each line is always sent on as exactly `LINE_LEN` complex points, 2048 by default. If the line has fewer valid samples, the remaining points are zeros, so the transform stage always sees a full frame.

There is one window table per channel. Software loads a table through a small write port. It first writes a channel-select value, which also rewinds the write pointer. It then writes entries one after another to the same data address, and each write stores the next entry in index order. A table keeps its contents across lines and across channel switches until it is overwritten or the block is reset. The channel input given with the start of a line picks the table used for that whole line.

Top module: `apod_window_mul`

## Requirements
- R1: While reset is high and after it is released, `out_valid` is low, the write pointer is 0 and the selected load channel is 0. Every table entry of both channels reads as zero (coefficient 0 + 0j) until it is written.
- R2: Each cycle with `tbl_we` high stores one entry at the write pointer of the selected channel and then advances the pointer by one. `tbl_wdata[15:0]` is the signed real part and `tbl_wdata[31:16]` is the signed imaginary part. Consecutive writes therefore fill indices 0, 1, 2, … in order.
- R3: A cycle with `sel_we` high loads `sel_ch` as the load channel and returns the write pointer to 0. If `tbl_we` is high in the same cycle, that entry goes to index 0 of the newly selected channel and the pointer becomes 1.
- R4: A write at index `LINE_LEN-1` wraps the pointer to 0, so later writes overwrite entries from index 0 upward.
- R5: Each channel has its own table. The value of `in_ch` in the start cycle selects the table for the whole line, and `in_ch` in later cycles of that line has no effect.
- R6: A line starts on a cycle with `in_valid` and `in_sol` both high while no frame is in progress. Two clock cycles later the first output point appears with `out_sol` high. Exactly `LINE_LEN` points follow in consecutive cycles, and `out_last` is high on the final point only.
- R7: Output point k of a line that carries sample x at index k uses table entry c = (cr, ci) of the chosen channel. The output is `out_re = clip((x*cr + 16384) >>> 15)` and `out_im = clip((x*ci + 16384) >>> 15)`, where `>>>` is a floor shift and clip limits to [-32768, 32767]. A coefficient of 32767 therefore acts as a gain of 1.0.
- R8: The one product that overflows, sample -32768 times coefficient -32768, saturates to 32767.
- R9: Samples are the run of consecutive `in_valid` cycles that begins at the start cycle. From the first frame cycle with `in_valid` low until the end of the frame, every output point is 0 + 0j, even if `in_valid` returns.
- R10: `in_sol` during a frame in progress neither restarts nor extends the frame. `in_valid` without `in_sol` while idle produces no output.
- R11: A new line may start in the cycle right after the final point of the previous line was accepted. Its frame then follows with no gap.
- R12: Entries beyond the last index written since reset read as zero. Loaded entries persist across lines and across writes to the other channel's table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table data write strobe |
| tbl_wdata | input | 32 | Entry to write: imaginary part in [31:16], real part in [15:0] |
| sel_we | input | 1 | Load-channel select write strobe (rewinds pointer) |
| sel_ch | input | CH_W | Channel whose table receives subsequent writes |
| in_valid | input | 1 | Input sample valid |
| in_sol | input | 1 | Start of line, qualified by in_valid |
| in_ch | input | CH_W | Channel of the line, sampled in the start cycle |
| in_data | input | 16 | Signed real input sample |
| out_valid | output | 1 | Output point valid |
| out_sol | output | 1 | First point of a frame |
| out_last | output | 1 | Final point of a frame |
| out_re | output | 16 | Signed real part of the windowed point |
| out_im | output | 16 | Signed imaginary part of the windowed point |

## Verification
The bound checker watches every cycle for the structural rules. It checks the two-cycle start latency, a frame of exactly `LINE_LEN` contiguous points with no restart inside it, zero output once the sample run has ended, padding that stays on once it begins, and the pointer rewinding and stepping with wrap. The arithmetic is checked only by the bench scenarios, which compare each point against a product computed in the bench. This covers rounding, the single saturation case, the choice of table by channel, and which entries a given load order leaves in place, including the wrap and the same-cycle select-and-write case.

// File: rtl/apod_pkg.sv
package apod_pkg;

    localparam int SAMP_W = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 15;
    localparam int PROD_W = SAMP_W + COEF_W;
    localparam int QW     = PROD_W - FRAC_W + 1;

    localparam logic signed [QW-1:0] QMAX = QW'((1 << (SAMP_W - 1)) - 1);
    localparam logic signed [QW-1:0] QMIN = -QMAX - QW'(1);

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    // Packed so that the imaginary part sits in the upper half of a write word
    typedef struct packed {
        coef_t im;
        coef_t re;
    } coef_pair_t;

    typedef struct packed {
        samp_t im;
        samp_t re;
    } cplx_t;

    // One point travelling from the sequencer into the product stage
    typedef struct packed {
        logic  sol;
        logic  last;
        logic  dok;
        samp_t x;
    } pt_t;

    // Round half up at bit FRAC_W-1, floor shift, then clip to the sample range
    function automatic samp_t round_sat(input logic signed [PROD_W-1:0] p);
        logic [PROD_W:0]          t;
        logic signed [QW-1:0]     q;
        t = {p[PROD_W-1], p} + {{(PROD_W + 1 - FRAC_W){1'b0}}, 1'b1, {(FRAC_W - 1){1'b0}}};
        q = $signed(t[PROD_W:FRAC_W]);
        if (q > QMAX)
            return QMAX[SAMP_W-1:0];
        else if (q < QMIN)
            return QMIN[SAMP_W-1:0];
        else
            return q[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/apod_loader.sv
module apod_loader import apod_pkg::*; #(
    parameter int NUM_CH   = 2,
    parameter int LINE_LEN = 2048,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W   = $clog2(LINE_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_we,
    input  logic [CH_W-1:0]      sel_ch,
    input  logic                 tbl_we,
    input  logic [2*COEF_W-1:0]  tbl_wdata,
    output logic [NUM_CH-1:0]    wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output coef_pair_t           wr_data,
    output logic [IDX_W-1:0]     wr_ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

    logic [CH_W-1:0]  sel_q;
    logic [IDX_W-1:0] ptr_q;
    logic [CH_W-1:0]  eff_ch;
    logic [IDX_W-1:0] eff_ptr;

    // A select write in the same cycle takes effect for that cycle's data write
    always_comb begin
        eff_ch  = sel_we ? sel_ch : sel_q;
        eff_ptr = sel_we ? '0 : ptr_q;
        wr_idx  = eff_ptr;
        wr_data = coef_pair_t'(tbl_wdata);
        for (int c = 0; c < NUM_CH; c++) begin
            wr_en[c] = tbl_we && (eff_ch == CH_W'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            ptr_q <= '0;
        end else begin
            if (sel_we)
                sel_q <= sel_ch;
            if (tbl_we)
                ptr_q <= (eff_ptr == LAST_IDX) ? '0 : eff_ptr + 1'b1;
            else if (sel_we)
                ptr_q <= '0;
        end
    end

    assign wr_ptr = ptr_q;

endmodule

// File: rtl/apod_bank.sv
module apod_bank import apod_pkg::*; #(
    parameter int LINE_LEN = 2048,
    localparam int IDX_W   = $clog2(LINE_LEN),
    localparam int FILL_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  coef_pair_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output coef_pair_t       rd_q
);

    coef_pair_t        mem [LINE_LEN];
    logic [FILL_W-1:0] fill_q;

    // Storage itself carries no reset; the fill mark hides stale contents
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    // Loads always begin at index 0, so written entries form a prefix
    always_ff @(posedge clk) begin
        if (rst)
            fill_q <= '0;
        else if (wr_en && ({1'b0, wr_idx} >= fill_q))
            fill_q <= {1'b0, wr_idx} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= ({1'b0, rd_idx} < fill_q) ? mem[rd_idx] : '0;
    end

endmodule

// File: rtl/apod_seq.sv
module apod_seq import apod_pkg::*; #(
    parameter int NUM_CH   = 2,
    parameter int LINE_LEN = 2048,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W   = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [CH_W-1:0]  in_ch,
    input  samp_t            in_data,
    output logic             pt_valid,
    output logic             pt_sol,
    output logic             pt_last,
    output logic             pt_dok,
    output samp_t            pt_x,
    output logic [IDX_W-1:0] pt_idx,
    output logic [CH_W-1:0]  pt_ch
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

    logic             busy_q;
    logic             run_q;
    logic [IDX_W-1:0] idx_q;
    logic [CH_W-1:0]  ch_q;
    logic             start;

    always_comb begin
        start    = !busy_q && in_valid && in_sol;
        pt_valid = start || busy_q;
        pt_sol   = start;
        pt_idx   = start ? '0 : idx_q;
        pt_ch    = start ? in_ch : ch_q;
        pt_last  = pt_valid && (pt_idx == LAST_IDX);
        // Once the sample run breaks, the rest of the frame is padding
        pt_dok   = start || (busy_q && run_q && in_valid);
        pt_x     = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            run_q  <= 1'b0;
            idx_q  <= '0;
            ch_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            run_q  <= 1'b1;
            idx_q  <= IDX_W'(1);
            ch_q   <= in_ch;
        end else if (busy_q) begin
            run_q  <= run_q && in_valid;
            idx_q  <= idx_q + 1'b1;
            if (pt_last)
                busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/apod_cmul.sv
module apod_cmul import apod_pkg::*; (
    input  samp_t      x,
    input  coef_pair_t c,
    output cplx_t      y
);

    logic signed [PROD_W-1:0] p_re;
    logic signed [PROD_W-1:0] p_im;

    always_comb begin
        p_re = PROD_W'($signed(x)) * PROD_W'($signed(c.re));
        p_im = PROD_W'($signed(x)) * PROD_W'($signed(c.im));
        y.re = round_sat(p_re);
        y.im = round_sat(p_im);
    end

endmodule

// File: rtl/apod_window_mul.sv
module apod_window_mul import apod_pkg::*; #(
    parameter int NUM_CH   = 2,
    parameter int LINE_LEN = 2048,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W   = $clog2(LINE_LEN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tbl_we,
    input  logic [2*COEF_W-1:0]        tbl_wdata,
    input  logic                       sel_we,
    input  logic [CH_W-1:0]            sel_ch,
    input  logic                       in_valid,
    input  logic                       in_sol,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMP_W-1:0]   in_data,
    output logic                       out_valid,
    output logic                       out_sol,
    output logic                       out_last,
    output logic signed [SAMP_W-1:0]   out_re,
    output logic signed [SAMP_W-1:0]   out_im
);

    // Table load path
    logic [NUM_CH-1:0] wr_en;
    logic [IDX_W-1:0]  wr_idx;
    coef_pair_t        wr_data;
    logic [IDX_W-1:0]  wr_ptr;

    apod_loader #(.NUM_CH(NUM_CH), .LINE_LEN(LINE_LEN)) u_load (
        .clk      (clk),
        .rst      (rst),
        .sel_we   (sel_we),
        .sel_ch   (sel_ch),
        .tbl_we   (tbl_we),
        .tbl_wdata(tbl_wdata),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_ptr   (wr_ptr)
    );

    // Frame sequencing
    logic             seq_valid;
    logic             seq_sol;
    logic             seq_last;
    logic             seq_dok;
    samp_t            seq_x;
    logic [IDX_W-1:0] seq_idx;
    logic [CH_W-1:0]  seq_ch;

    apod_seq #(.NUM_CH(NUM_CH), .LINE_LEN(LINE_LEN)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sol  (in_sol),
        .in_ch   (in_ch),
        .in_data (in_data),
        .pt_valid(seq_valid),
        .pt_sol  (seq_sol),
        .pt_last (seq_last),
        .pt_dok  (seq_dok),
        .pt_x    (seq_x),
        .pt_idx  (seq_idx),
        .pt_ch   (seq_ch)
    );

    // One table per channel, all read at the current point index
    coef_pair_t bank_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        apod_bank #(.LINE_LEN(LINE_LEN)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en[g]),
            .wr_idx (wr_idx),
            .wr_data(wr_data),
            .rd_idx (seq_idx),
            .rd_q   (bank_q[g])
        );
    end

    // Stage 1: point aligned with the registered table read
    logic            s1_valid;
    pt_t             s1_pt;
    logic [CH_W-1:0] s1_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_pt    <= '0;
            s1_ch    <= '0;
        end else begin
            s1_valid <= seq_valid;
            s1_pt    <= '{sol: seq_sol, last: seq_last, dok: seq_dok, x: seq_x};
            s1_ch    <= seq_ch;
        end
    end

    coef_pair_t coef_sel;
    samp_t      x_eff;
    cplx_t      prod;

    always_comb begin
        coef_sel = bank_q[s1_ch];
        x_eff    = s1_pt.dok ? s1_pt.x : '0;
    end

    apod_cmul u_mul (
        .x(x_eff),
        .c(coef_sel),
        .y(prod)
    );

    // Stage 2: registered output
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_last  <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s1_valid;
            out_sol   <= s1_valid && s1_pt.sol;
            out_last  <= s1_valid && s1_pt.last;
            out_re    <= s1_valid ? prod.re : '0;
            out_im    <= s1_valid ? prod.im : '0;
        end
    end

endmodule

// File: rtl/apod_window_chk.sv
module apod_window_chk #(
    parameter int LINE_LEN = 2048,
    localparam int IDX_W   = $clog2(LINE_LEN)
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_sol,
    input logic               sel_we,
    input logic               tbl_we,
    input logic [IDX_W-1:0]   wr_ptr,
    input logic               pt_valid,
    input logic               pt_sol,
    input logic               pt_last,
    input logic               pt_dok,
    input logic               out_valid,
    input logic               out_sol,
    input logic               out_last,
    input logic [15:0]        out_re,
    input logic [15:0]        out_im
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

    logic [IDX_W:0] pts_q;
    logic           dok_d1;
    logic           dok_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pts_q  <= '0;
            dok_d1 <= 1'b0;
            dok_d2 <= 1'b0;
        end else begin
            if (out_valid)
                pts_q <= out_sol ? (IDX_W + 1)'(1) : pts_q + 1'b1;
            dok_d1 <= pt_valid && pt_dok;
            dok_d2 <= dok_d1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (rst)
        sel_we && !tbl_we |=> wr_ptr == '0); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        tbl_we && !sel_we |=> wr_ptr == (($past(wr_ptr) == LAST_IDX) ? '0 : $past(wr_ptr) + 1'b1)); // R4

    AST_SOL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> $past(in_valid && in_sol, 2)); // R6

    AST_SOL_DELAY: assert property (@(posedge clk) disable iff (rst)
        pt_valid && pt_sol |=> ##1 out_sol); // R6

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> (out_sol ? '0 : pts_q) == (IDX_W + 1)'(LINE_LEN - 1)); // R6

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |=> out_valid && !out_sol); // R10

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && !dok_d2 |-> out_re == '0 && out_im == '0); // R9

    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        pt_valid && !pt_dok && !pt_last |=> pt_valid && !pt_dok); // R9

endmodule

bind apod_window_mul apod_window_chk #(.LINE_LEN(LINE_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sol   (in_sol),
    .sel_we   (sel_we),
    .tbl_we   (tbl_we),
    .wr_ptr   (wr_ptr),
    .pt_valid (seq_valid),
    .pt_sol   (seq_sol),
    .pt_last  (seq_last),
    .pt_dok   (seq_dok),
    .out_valid(out_valid),
    .out_sol  (out_sol),
    .out_last (out_last),
    .out_re   (out_re),
    .out_im   (out_im)
);

// File: tb/sim_apod_window_mul.sv
module sim_apod_window_mul;

    localparam int TL   = 32;
    localparam int MAXF = 64;
    localparam int WD   = 150000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tbl_we = 1'b0;
    logic [31:0]        tbl_wdata = '0;
    logic               sel_we = 1'b0;
    logic [0:0]         sel_ch = '0;
    logic               in_valid = 1'b0;
    logic               in_sol = 1'b0;
    logic [0:0]         in_ch = '0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic               out_sol;
    logic               out_last;
    logic signed [15:0] out_re;
    logic signed [15:0] out_im;

    apod_window_mul #(.NUM_CH(2), .LINE_LEN(TL)) u0 (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
        .sel_we(sel_we), .sel_ch(sel_ch),
        .in_valid(in_valid), .in_sol(in_sol), .in_ch(in_ch), .in_data(in_data),
        .out_valid(out_valid), .out_sol(out_sol), .out_last(out_last),
        .out_re(out_re), .out_im(out_im)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Bench model of the tables
    int m_re [2][TL];
    int m_im [2][TL];
    int m_fill [2];
    int m_ptr = 0;
    int m_sel = 0;

    // Expected frames
    int    exp_re  [MAXF][TL];
    int    exp_im  [MAXF][TL];
    string exp_tag [MAXF];
    int    sol_cyc [MAXF];
    int    drv_fr = 0;
    int    mon_fr = 0;
    int    mon_k  = 0;
    int    cur_fr = 0;
    bit    mon_act = 0;

    function automatic int rs(input int x, input int c);
        longint p;
        p = longint'(x) * longint'(c) + 64'sd16384;
        p = p >>> 15;
        if (p > 32767) return 32767;
        if (p < -32768) return -32768;
        return int'(p);
    endfunction

    function automatic int wrap16(input int v);
        return ((v % 65536) + 65536) % 65536 - 32768;
    endfunction

    function automatic int smp_val(input int seed, input int k);
        case (k)
            0: return 32767;
            1: return -32768;
            2: return 0;
            3: return -32768;
            default: return wrap16(k * 4099 + seed * 977 + 311);
        endcase
    endfunction

    function automatic int cre(input int ch, input int k);
        case (k)
            0, 1: return 32767;
            2, 3: return -32768;
            default: return wrap16(k * 2503 + ch * 7001 + 17);
        endcase
    endfunction

    function automatic int cim(input int ch, input int k);
        case (k)
            0: return 0;
            1, 3: return -32768;
            default: return wrap16(k * 1549 + ch * 3331 + 5);
        endcase
    endfunction

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            mon_act = 0;
        end else if (out_valid) begin
            if (out_sol) begin
                chk(mon_fr < drv_fr, "R10 unexpected frame", mon_fr, drv_fr);
                cur_fr = (mon_fr < MAXF) ? mon_fr : MAXF - 1;
                chk(cyc - sol_cyc[cur_fr] == 2, "R6 start latency", cyc - sol_cyc[cur_fr], 2);
                mon_fr++;
                mon_k = 0;
                mon_act = 1;
            end else begin
                chk(mon_act, "R10 point outside frame", 0, 1);
            end
            if (mon_act && mon_k < TL) begin
                chk(int'(out_re) == exp_re[cur_fr][mon_k], {exp_tag[cur_fr], " re"},
                    int'(out_re), exp_re[cur_fr][mon_k]);
                chk(int'(out_im) == exp_im[cur_fr][mon_k], {exp_tag[cur_fr], " im"},
                    int'(out_im), exp_im[cur_fr][mon_k]);
                chk(out_last == (mon_k == TL - 1), "R6 last flag", int'(out_last), int'(mon_k == TL - 1));
                if (out_last) mon_act = 0;
                mon_k++;
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        tbl_we = 0; sel_we = 0; in_valid = 0; in_sol = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        m_fill[0] = 0; m_fill[1] = 0; m_ptr = 0; m_sel = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    endtask

    task automatic model_write(input int re, input int im);
        m_re[m_sel][m_ptr] = re;
        m_im[m_sel][m_ptr] = im;
        if (m_ptr >= m_fill[m_sel]) m_fill[m_sel] = m_ptr + 1;
        m_ptr = (m_ptr + 1) % TL;
    endtask

    task automatic wr_sel(input int ch);
        sel_we = 1'b1; sel_ch = 1'(ch);
        @(negedge clk);
        sel_we = 1'b0;
        m_sel = ch; m_ptr = 0;
    endtask

    task automatic tbl_write(input int re, input int im);
        tbl_we = 1'b1; tbl_wdata = {16'(im), 16'(re)};
        @(negedge clk);
        tbl_we = 1'b0;
        model_write(re, im);
    endtask

    task automatic sel_and_write(input int ch, input int re, input int im);
        sel_we = 1'b1; sel_ch = 1'(ch);
        tbl_we = 1'b1; tbl_wdata = {16'(im), 16'(re)};
        @(negedge clk);
        sel_we = 1'b0; tbl_we = 1'b0;
        m_sel = ch; m_ptr = 0;
        model_write(re, im);
    endtask

    // Drives one line starting at the current negedge
    task automatic send_line(input int ch, input int nvalid, input bit resume, input bit midsol,
                             input bit idle, input int seed, input string tag);
        int f;
        f = drv_fr;
        for (int k = 0; k < TL; k++) begin
            int x;
            int cr;
            int ci;
            x  = (k < nvalid) ? smp_val(seed, k) : 0;
            cr = (k < m_fill[ch]) ? m_re[ch][k] : 0;
            ci = (k < m_fill[ch]) ? m_im[ch][k] : 0;
            exp_re[f][k] = rs(x, cr);
            exp_im[f][k] = rs(x, ci);
        end
        exp_tag[f] = tag;
        for (int k = 0; k < TL; k++) begin
            in_valid = (k < nvalid) || (resume && k > nvalid);
            in_sol   = (k == 0) || (midsol && (k == 5 || k == nvalid + 1));
            in_ch    = (k == 0) ? 1'(ch) : 1'(ch ^ 1);
            in_data  = (k < nvalid) ? 16'(smp_val(seed, k)) : 16'h1234;
            if (k == 0) begin
                sol_cyc[f] = cyc;
                drv_fr = drv_fr + 1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sol   = 1'b0;
        if (idle) repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: cycles %0d expected below %0d", cyc, WD);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R1 R12: nothing loaded yet, both tables read as zero
        send_line(0, TL, 0, 0, 1, 1, "R1 R12 unloaded ch0");
        send_line(1, TL, 0, 0, 1, 2, "R1 R12 unloaded ch1");

        // R2: fill both tables in index order
        wr_sel(0);
        for (int k = 0; k < TL; k++) tbl_write(cre(0, k), cim(0, k));
        wr_sel(1);
        for (int k = 0; k < TL; k++) tbl_write(cre(1, k), cim(1, k));

        // R5 R7 R8: full lines on each channel, several sample patterns
        for (int s = 3; s < 6; s++) begin
            send_line(0, TL, 0, 0, 1, s, "R2 R5 R7 R8 ch0");
            send_line(1, TL, 0, 0, 1, s, "R2 R5 R7 R8 ch1");
        end

        // R9 R10: short lines, valid returning after the gap, stray starts
        send_line(0, 10, 1, 1, 1, 7, "R9 R10 short");
        send_line(1, 1, 1, 1, 1, 8, "R9 R10 single");
        send_line(0, TL - 1, 1, 1, 1, 9, "R9 R10 one short");
        send_line(1, 6, 0, 0, 1, 10, "R9 gap stays");

        // R11: back-to-back lines
        send_line(0, TL, 0, 0, 0, 11, "R11 first");
        send_line(1, 7, 0, 0, 0, 12, "R11 second");
        send_line(0, TL, 0, 1, 1, 13, "R11 third");

        // R10: valid without start while idle gives nothing
        in_valid = 1'b1; in_sol = 1'b0; in_data = 16'sd1000;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 idle valid", int'(out_valid), 0);
        end
        in_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 idle valid", int'(out_valid), 0);
        end

        // R4: pointer wraps past the last index
        wr_sel(1);
        for (int k = 0; k < TL + 3; k++) tbl_write(wrap16(k * 311 - 5000), wrap16(-k * 177 + 90));
        send_line(1, TL, 0, 0, 1, 14, "R4 wrap ch1");
        send_line(0, TL, 0, 0, 1, 15, "R12 ch0 kept");

        // R3: reselect rewinds, same-cycle select and write
        wr_sel(0);
        for (int k = 0; k < 4; k++) tbl_write(1000 + k, -2000 - k);
        wr_sel(0);
        for (int k = 0; k < 2; k++) tbl_write(-7000 + k, 6000 + k);
        sel_and_write(1, 12345, -23456);
        tbl_write(-111, 222);
        send_line(0, TL, 0, 0, 1, 16, "R3 rewind ch0");
        send_line(1, TL, 0, 0, 1, 17, "R3 sel+write ch1");

        // R1 R12: reset clears tables, then a partial load
        do_reset();
        send_line(0, TL, 0, 0, 1, 18, "R1 R12 after reset ch0");
        send_line(1, TL, 0, 0, 1, 19, "R1 R12 after reset ch1");
        wr_sel(0);
        for (int k = 0; k < 5; k++) tbl_write(cre(0, k), cim(0, k));
        send_line(0, TL, 0, 0, 1, 20, "R12 partial ch0");

        repeat (6) @(negedge clk);
        chk(mon_fr == drv_fr, "R6 frames seen", mon_fr, drv_fr);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule